// File: doc/BRIEF.md
# Dual-Channel Vectored Interrupt Requester

This block lets a bus peripheral take bus mastership and hand the processor one of two interrupt vectors. Two request channels, A and B, each combine a device request level with an enable level. A channel whose request and enable are both high raises the single shared bus request line. Once granted, the block acknowledges the grant and waits for the bus to go quiet. It then takes the bus as master, strobes the interrupt and drives the vector onto the data lines. It lets go when the processor returns slave sync.

Channel A outranks channel B, and the two vectors differ only in data bit 2. After a channel has been serviced it stays silent until its condition has dropped and come back. This keeps one long-held level from raising repeated interrupts. As an option, a pending non-processor request holds off completion of the interrupt cycle. A bus initialize pulse returns everything to the idle, re-armed state.

Top module: `irq_requester`

## Requirements
- R1: The block raises `bus_req` for a channel only while that channel's request and enable inputs are both high and the channel is armed.
- R2: Both channels share the single `bus_req` line. When both are active at the moment the grant arrives, channel A is served first.
- R3: `sack` rises on the clock edge that sees `grant_in` while `bus_req` is high. `busy_out` rises only on the edge after one where `sack` was high and `grant_in`, `busy_in` and `ssyn_in` were all low.
- R4: While the block is idle (no request, no acknowledge, not master), `grant_out` equals `grant_in`. Otherwise `grant_out` is 0.
- R5: The vector is a 16-bit word. Bits 8:3 hold parameter `VEC_HI` (default 6'o30), bit 2 is 0 for channel A and 1 for channel B, and bits 1:0 and 15:9 are 0. The defaults are 0300 (192) and 0304 (196) in octal.
- R6: While master with the strobe active, `ssyn_in` high ends mastership: `busy_out` is 0 on the next cycle.
- R7: A serviced channel makes no further request while its request and enable stay high. It must see at least one clock edge with the pair not both high before it is armed again.
- R8: With `NPR_HOLD`=1 (default), `intr_out` stays low while master and `npr_in` is high. The strobe appears once `npr_in` is low.
- R9: `bus_init` high at a clock edge returns the block to idle and re-arms both channels.
- R10: `vec_data` is 0 except while `busy_out` and `intr_out` are both high.
- R11: If no channel is active any more while the block is requesting but not yet granted, `bus_req` drops on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_init | input | 1 | Synchronous bus initialize |
| req_a | input | 1 | Device request level, channel A |
| ena_a | input | 1 | Interrupt enable level, channel A |
| req_b | input | 1 | Device request level, channel B |
| ena_b | input | 1 | Interrupt enable level, channel B |
| grant_in | input | 1 | Bus grant arriving from upstream |
| busy_in | input | 1 | Bus busy as seen on the bus |
| ssyn_in | input | 1 | Slave sync from the bus |
| npr_in | input | 1 | Non-processor request line |
| bus_req | output | 1 | Bus request on the shared priority level |
| grant_out | output | 1 | Bus grant passed downstream |
| sack | output | 1 | Selection acknowledge |
| busy_out | output | 1 | Bus busy driven while master |
| intr_out | output | 1 | Interrupt strobe |
| vec_data | output | 16 | Vector driven on the data lines |

## Verification
The hardest situation to reach is a channel that has already been served while its request and enable are still held high. The block must stay silent in that state, yet both inputs look ready. The bench keeps its own model of each channel's armed state from the levels it drives. Random rounds hold inputs for several cycles, so serviced-and-still-high channels occur often. Directed cases then drop and restore one enable to re-arm the channel, and pulse `bus_init` over a disarmed channel. Handshake holds on `busy_in` and `npr_in` are randomized so that the acknowledge and NPR waiting states are entered with varying lengths.

// File: rtl/irq_requester.sv
module irq_requester #(
  parameter int DATA_W = 16,
  parameter logic [5:0] VEC_HI = 6'o30,
  parameter bit NPR_HOLD = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_init,
  input  logic              req_a,
  input  logic              ena_a,
  input  logic              req_b,
  input  logic              ena_b,
  input  logic              grant_in,
  input  logic              busy_in,
  input  logic              ssyn_in,
  input  logic              npr_in,
  output logic              bus_req,
  output logic              grant_out,
  output logic              sack,
  output logic              busy_out,
  output logic              intr_out,
  output logic [DATA_W-1:0] vec_data
);
  localparam int PAD_W = DATA_W - 9;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_ACK, S_MST} state_t;
  state_t state;

  logic cond_a, cond_b, armed_a, armed_b, act_a, act_b, sel_b, done;

  assign cond_a = req_a & ena_a;
  assign cond_b = req_b & ena_b;
  assign act_a  = cond_a & armed_a;
  assign act_b  = cond_b & armed_b;

  assign bus_req   = (state == S_REQ);
  assign sack      = (state == S_ACK);
  assign busy_out  = (state == S_MST);
  assign grant_out = grant_in & (state == S_IDLE);
  assign intr_out  = busy_out & ~(NPR_HOLD & npr_in);
  assign done      = intr_out & ssyn_in;
  assign vec_data  = (busy_out && intr_out) ? {{PAD_W{1'b0}}, VEC_HI, sel_b, 2'b00} : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sel_b <= 1'b0;
    end else if (bus_init) begin
      state <= S_IDLE;
      sel_b <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (act_a || act_b) state <= S_REQ;
        S_REQ: begin
          if (!(act_a || act_b)) state <= S_IDLE;
          else if (grant_in) begin
            state <= S_ACK;
            sel_b <= ~act_a;
          end
        end
        S_ACK: if (!grant_in && !busy_in && !ssyn_in) state <= S_MST;
        S_MST: if (done) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_a <= 1'b1;
      armed_b <= 1'b1;
    end else if (bus_init) begin
      armed_a <= 1'b1;
      armed_b <= 1'b1;
    end else begin
      if (!cond_a) armed_a <= 1'b1;
      else if (done && !sel_b) armed_a <= 1'b0;
      if (!cond_b) armed_b <= 1'b1;
      else if (done && sel_b) armed_b <= 1'b0;
    end
  end

  AST_SACK_NEEDS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sack) |-> $past(bus_req && grant_in)); // R3
  AST_BUSY_QUIET_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_out) |-> $past(sack && !grant_in && !busy_in && !ssyn_in && !bus_init)); // R3
  AST_NO_PASS_WHILE_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req || sack || busy_out) |-> !grant_out); // R4
  AST_VEC_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    vec_data[1:0] == 2'b00); // R5
  AST_RELEASE_ON_SSYN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_out && intr_out && ssyn_in && !bus_init) |=> !busy_out); // R6
  AST_NPR_BLOCKS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (NPR_HOLD && npr_in) |-> !intr_out); // R8
  AST_INIT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_init |=> (!bus_req && !sack && !busy_out)); // R9
  AST_VEC_ONLY_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_data != '0) |-> (busy_out && intr_out)); // R10
  AST_WITHDRAW: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !grant_in && !cond_a && !cond_b) |=> !bus_req); // R11
endmodule

// File: tb/irq_requester_bench.sv
module irq_requester_bench;
  logic clk = 0, rst_n = 0, bus_init = 0;
  logic req_a = 0, ena_a = 0, req_b = 0, ena_b = 0;
  logic grant_in = 0, busy_in = 0, ssyn_in = 0, npr_in = 0;
  logic bus_req, grant_out, sack, busy_out, intr_out;
  logic [15:0] vec_data;
  int errors = 0, checks = 0;
  bit ma = 1, mb = 1;

  irq_requester u_irq_requester (.*);

  always #5 clk = ~clk;

  function automatic int exp_vec(bit b);
    return 'o300 + (b ? 4 : 0);
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic set_in(bit ra, bit ea, bit rb, bit eb);
    req_a = ra; ena_a = ea; req_b = rb; ena_b = eb;
    if (!(ra && ea)) ma = 1;
    if (!(rb && eb)) mb = 1;
  endtask

  task automatic serve(bit exp_b, int busy_hold, int npr_hold, string tag);
    for (int i = 0; i < 10 && !bus_req; i++) step();
    chk(bus_req == 1, {tag, " R2 request raised"}, bus_req, 1);
    grant_in = 1;
    for (int i = 0; i < 10 && !sack; i++) step();
    chk(sack == 1, {tag, " R3 sack after grant"}, sack, 1);
    chk(grant_out == 0, {tag, " R4 grant blocked"}, grant_out, 0);
    chk(vec_data == 0, {tag, " R10 no vector before master"}, vec_data, 0);
    if (busy_hold > 0) busy_in = 1;
    if (npr_hold > 0) npr_in = 1;
    grant_in = 0;
    for (int i = 0; i < busy_hold; i++) begin
      step();
      chk(busy_out == 0 && sack == 1, {tag, " R3 waits for quiet bus"}, busy_out, 0);
    end
    busy_in = 0;
    for (int i = 0; i < 10 && !busy_out; i++) step();
    chk(busy_out == 1, {tag, " R3 busy asserted"}, busy_out, 1);
    for (int i = 0; i < npr_hold; i++) begin
      chk(intr_out == 0 && vec_data == 0, {tag, " R8 npr holds strobe"}, intr_out, 0);
      step();
    end
    npr_in = 0;
    #1;
    chk(intr_out == 1, {tag, " R8 strobe after npr"}, intr_out, 1);
    chk(vec_data == exp_vec(exp_b), {tag, " R5 vector"}, vec_data, exp_vec(exp_b));
    ssyn_in = 1;
    step();
    chk(busy_out == 0, {tag, " R6 release on ssyn"}, busy_out, 0);
    ssyn_in = 0;
    if (exp_b) mb = 0; else ma = 0;
    step();
  endtask

  initial begin
    #2000000;
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    step(); step();
    rst_n = 1;
    step();
    chk(bus_req == 0 && sack == 0 && busy_out == 0, "R9 reset idle", bus_req, 0);
    chk(vec_data == 0, "R10 reset vector", vec_data, 0);
    grant_in = 1; #1;
    chk(grant_out == 1, "R4 pass-through high", grant_out, 1);
    grant_in = 0; #1;
    chk(grant_out == 0, "R4 pass-through low", grant_out, 0);

    set_in(1, 0, 0, 1); step(); step(); step();
    chk(bus_req == 0, "R1 request without enable", bus_req, 0);

    set_in(1, 1, 1, 1);
    serve(0, 2, 0, "both active A first");
    serve(1, 0, 2, "then B");
    step(); step(); step();
    chk(bus_req == 0, "R7 both serviced stay silent", bus_req, 0);

    set_in(1, 0, 1, 1); step();
    set_in(1, 1, 1, 1);
    serve(0, 1, 1, "A re-armed");

    bus_init = 1; step(); bus_init = 0; ma = 1; mb = 1;
    step(); step();
    chk(bus_req == 1, "R9 init re-arms", bus_req, 1);
    serve(0, 0, 0, "after init");
    serve(1, 0, 0, "after init B");

    set_in(0, 0, 0, 0); step();
    set_in(0, 0, 1, 1); step(); step();
    chk(bus_req == 1, "R11 request up", bus_req, 1);
    set_in(0, 0, 0, 0); step(); step();
    chk(bus_req == 0, "R11 withdraw", bus_req, 0);
    bus_init = 1; step();
    chk(bus_req == 0, "R9 init clears", bus_req, 0);
    bus_init = 0;

    for (int n = 0; n < 60; n++) begin
      bit ra = 1'($urandom), ea = 1'($urandom), rb = 1'($urandom), eb = 1'($urandom);
      bit aa, ab;
      set_in(ra, ea, rb, eb);
      step(); step(); step();
      aa = ra && ea && ma;
      ab = rb && eb && mb;
      if (!aa && !ab)
        chk(bus_req == 0, "R1 R7 random no request", bus_req, 0);
      else
        serve(!aa, int'($urandom % 3), int'($urandom % 3), "random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule